// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is a master-mode serial port that marks each frame with a frame-sync pulse one serial clock long. Software or a DMA engine writes words of up to 16 bits into an 8-entry transmit queue. While the port is enabled and that queue holds a word, the block generates a serial clock from the system clock and sends the oldest word most significant bit first. At the same time it shifts in the far end's reply and pushes the reply into an 8-entry receive queue. The reply is right-justified and zero-extended.

Frame length is set per frame from 4 to 16 bits. In single mode the line goes quiet between frames. In continuous mode the next frame's sync pulse overlaps the previous frame's last bit, so data bits flow with no gap for as long as words are queued. Two level-based request outputs ask an external DMA engine to refill the transmit queue or drain the receive queue, and each is gated by its own enable input. When the port is idle the serial clock and frame sync are low and the data output enable is off.

Top module: `fps_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sclk`, `fsync` and `txd_oe` are all 0. After reset `tx_full`=0, `rx_empty`=1 and both DMA requests are 0.
- R2: `fsync` rises together with a rising edge of `sclk` and stays high for exactly one serial clock period. It falls on the next rising edge of `sclk`.
- R3: A frame starts only while `cfg_enable`=1 and the transmit queue is not empty. Starting a frame removes the oldest queued word. With `cfg_enable`=0, queued words stay queued and no `fsync` pulse occurs.
- R4: Data changes on the rising edge of `sclk`. The first data bit, on the rising edge that ends the sync pulse, is the most significant bit of the frame, and `txd_oe`=1 from that edge on. The frame's width is the low `cfg_frame_bits` bits of the word, and it is sent MSB first.
- R5: The frame width is taken from `cfg_frame_bits` when each frame starts. Values below 4 act as 4 and values above 16 act as 16.
- R6: `rxd` is sampled on each falling edge of `sclk` during data bits, MSB first. A finished frame is pushed into the receive queue right-justified, with the bits above the frame width equal to 0.
- R7: With `cfg_continuous`=1 and words queued, the next `fsync` pulse is driven during the period of the previous frame's LSB. Consecutive sync rising edges are then exactly N serial periods apart (N = frame width), and `txd_oe` stays 1 across the burst.
- R8: With `cfg_continuous`=0, `txd_oe` returns to 0 after every frame. Consecutive sync rising edges are at least N+2 serial periods apart.
- R9: A write to the transmit queue while `tx_full`=1 is ignored, so the dropped word is never sent.
- R10: `tx_dma_req` is 1 exactly when `cfg_tx_dma_en`=1 and the transmit queue holds at most 4 of its 8 entries.
- R11: `rx_dma_req` is 1 exactly when `cfg_rx_dma_en`=1 and the receive queue holds at least 4 of its 8 entries.
- R12: A received frame that arrives while the receive queue is full is dropped and sets `rx_overrun`. That flag stays 1 until a cycle with `rx_ovr_clr`=1.
- R13: The serial clock period is 2 × `cfg_half_div` system clock cycles, and a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Allows frames to start |
| cfg_continuous | input | 1 | 1: back-to-back frames, 0: single frames with an idle gap |
| cfg_frame_bits | input | 5 | Frame width in bits (4 to 16, clamped) |
| cfg_half_div | input | DIV_W (8) | Half serial period in system clock cycles |
| cfg_tx_dma_en | input | 1 | Enables the transmit DMA request |
| cfg_rx_dma_en | input | 1 | Enables the receive DMA request |
| tx_wr_en | input | 1 | Write strobe for the transmit queue |
| tx_wr_data | input | DATA_W (16) | Word to transmit, right-justified |
| tx_full | output | 1 | Transmit queue full |
| rx_rd_en | input | 1 | Removes the head of the receive queue |
| rx_rd_data | output | DATA_W (16) | Head of the receive queue (show-ahead) |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky flag for a dropped receive frame |
| rx_ovr_clr | input | 1 | Clears `rx_overrun` |
| tx_dma_req | output | 1 | Transmit refill request |
| rx_dma_req | output | 1 | Receive drain request |
| sclk | output | 1 | Serial clock, low when idle |
| fsync | output | 1 | Frame-sync pulse |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Output enable for `txd` (0 means high impedance) |
| rxd | input | 1 | Serial receive data |

## Verification
The bench loops `txd` back to `rxd`, sometimes inverted, and rebuilds every frame from the pins on falling clock edges. This catches designs that send LSB first, start data one edge late, or leave stale upper bits in a narrow received word.

The burst tests measure the distance between sync pulses in system cycles. A design that waited for the LSB to finish before raising the next pulse would show N+1 periods instead of N. A design without the single-mode gap would show fewer than N+2 periods.

Queue edge cases are covered by a ninth write into a full transmit queue, which a faulty design would send as a ninth frame, and by a ninth frame into a full receive queue. There a faulty design would overwrite the oldest word or fail to keep the overrun flag set. The DMA thresholds are checked at exactly 4 and 5 entries, where an off-by-one comparison flips the request.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the frame-pulse serial master.
// Assumes frames are never narrower than FPS_MIN_BITS.
package fps_pkg;
    localparam int unsigned FPS_MIN_BITS = 4;

    // Sequencer state: waiting, clocking a frame, enforcing the single-mode gap
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_GAP  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/fps_fifo.sv
`timescale 1ns/1ps
// Synchronous show-ahead queue.
// Does: stores WIDTH-bit words, presents the oldest at rdata, reports level.
// Assumes: push while full and pop while empty are ignored.
module fps_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [WIDTH-1:0]               wdata,
    input  logic                           pop,
    output logic [WIDTH-1:0]               rdata,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     level
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    level_q;
    logic             do_push, do_pop;

    assign full    = (level_q == CW'(DEPTH));
    assign empty   = (level_q == '0);
    assign level   = level_q;
    assign rdata   = mem[rd_ptr_q];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Storage write; the array is not reset
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= wdata;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
            if (do_push && !do_pop)      level_q <= level_q + 1'b1;
            else if (do_pop && !do_push) level_q <= level_q - 1'b1;
        end
    end

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level_q == $past(level_q))); // R9
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= CW'(DEPTH)); // R9
endmodule

// File: rtl/fps_dma_req.sv
`timescale 1ns/1ps
// Level-based DMA request generation for both queues.
// Does: asks for refill when the transmit queue is at most half full and
// for draining when the receive queue is at least half full.
// Assumes: DEPTH is even; requests are level signals, not pulses.
module fps_dma_req #(
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_en,
    input  logic                       rx_en,
    input  logic [$clog2(DEPTH+1)-1:0] tx_level,
    input  logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       tx_req,
    output logic                       rx_req
);
    localparam int unsigned CW   = $clog2(DEPTH+1);
    localparam int unsigned HALF = DEPTH / 2;

    // Threshold compare, gated by each enable
    always_comb begin
        tx_req = tx_en && (tx_level <= CW'(HALF));
        rx_req = rx_en && (rx_level >= CW'(HALF));
    end

    AST_TX_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (tx_en && tx_level <= CW'(HALF))); // R10
    AST_RX_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req |-> (rx_en && rx_level >= CW'(HALF))); // R11
endmodule

// File: rtl/fps_engine.sv
`timescale 1ns/1ps
// Frame sequencer, clock divider and shifters.
// Does: divides clk into sclk, pulses fsync for one period at frame start,
// shifts words out MSB first on rising sclk, samples rxd on falling sclk,
// and chains frames in continuous mode.
// Assumes: tx_data is show-ahead; tx_pop and rx_push are single-cycle strobes.
module fps_engine
    import fps_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DIV_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         continuous,
    input  logic [$clog2(DATA_W+1)-1:0]  cfg_bits,
    input  logic [DIV_W-1:0]             cfg_div,
    input  logic                         tx_empty,
    input  logic [DATA_W-1:0]            tx_data,
    output logic                         tx_pop,
    output logic                         rx_push,
    output logic [DATA_W-1:0]            rx_data,
    input  logic                         rxd,
    output logic                         sclk,
    output logic                         fsync,
    output logic                         txd,
    output logic                         txd_oe
);
    localparam int unsigned BW = $clog2(DATA_W+1);
    localparam int unsigned IW = $clog2(DATA_W);

    eng_state_t        state_q;
    logic              sclk_q, fs_q, oe_q, txd_q, dphase_q, gap_half_q;
    logic [DATA_W-1:0] sh_q, rx_sh_q, rx_sh_next, rx_mask;
    logic [BW-1:0]     nbits_q, rx_n_q, bit_left_q, rx_cnt_q, width_req;
    logic [DIV_W-1:0]  div_cnt_q, div_last;
    logic [IW-1:0]     msb_idx;
    logic              half_tick, rise_ev, fall_ev, start_frame, chain;

    // Clamp the requested width into the legal range
    always_comb begin
        if (cfg_bits < BW'(FPS_MIN_BITS))  width_req = BW'(FPS_MIN_BITS);
        else if (cfg_bits > BW'(DATA_W))   width_req = BW'(DATA_W);
        else                               width_req = cfg_bits;
    end

    // Divider terminal count; zero behaves as one
    always_comb begin
        div_last  = (cfg_div == '0) ? '0 : cfg_div - 1'b1;
        half_tick = (div_cnt_q >= div_last);
    end

    // Event decode for the current cycle
    always_comb begin
        rise_ev     = (state_q == ENG_RUN) && half_tick && !sclk_q;
        fall_ev     = (state_q == ENG_RUN) && half_tick && sclk_q;
        start_frame = (state_q == ENG_IDLE) && en && !tx_empty;
        chain       = rise_ev && (bit_left_q == BW'(1)) && continuous && en && !tx_empty;
        tx_pop      = start_frame || chain;
        msb_idx     = IW'(nbits_q - 1'b1);
    end

    // Receive word assembly and right-justified masking
    always_comb begin
        rx_sh_next = {rx_sh_q[DATA_W-2:0], rxd};
        for (int i = 0; i < DATA_W; i++) rx_mask[i] = (i < int'(rx_n_q));
        rx_data = rx_sh_next & rx_mask;
        rx_push = fall_ev && dphase_q && (rx_cnt_q == rx_n_q - 1'b1);
    end

    // Main sequencer: divider, pin registers, shifters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ENG_IDLE;
            sclk_q     <= 1'b0;
            fs_q       <= 1'b0;
            oe_q       <= 1'b0;
            txd_q      <= 1'b0;
            dphase_q   <= 1'b0;
            gap_half_q <= 1'b0;
            sh_q       <= '0;
            rx_sh_q    <= '0;
            nbits_q    <= BW'(FPS_MIN_BITS);
            rx_n_q     <= BW'(FPS_MIN_BITS);
            bit_left_q <= '0;
            rx_cnt_q   <= '0;
            div_cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start_frame) begin
                        state_q    <= ENG_RUN;
                        sclk_q     <= 1'b1;
                        fs_q       <= 1'b1;
                        sh_q       <= tx_data;
                        nbits_q    <= width_req;
                        bit_left_q <= width_req;
                        div_cnt_q  <= '0;
                        dphase_q   <= 1'b0;
                        rx_cnt_q   <= '0;
                    end
                end
                ENG_RUN: begin
                    if (!half_tick) begin
                        div_cnt_q <= div_cnt_q + 1'b1;
                    end else begin
                        div_cnt_q <= '0;
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                            if (dphase_q) begin
                                rx_sh_q  <= rx_sh_next;
                                rx_cnt_q <= (rx_cnt_q == rx_n_q - 1'b1) ? '0 : rx_cnt_q + 1'b1;
                            end
                        end else if (bit_left_q != '0) begin
                            sclk_q     <= 1'b1;
                            fs_q       <= 1'b0;
                            oe_q       <= 1'b1;
                            dphase_q   <= 1'b1;
                            txd_q      <= sh_q[msb_idx];
                            sh_q       <= {sh_q[DATA_W-2:0], 1'b0};
                            bit_left_q <= bit_left_q - 1'b1;
                            if (bit_left_q == nbits_q) rx_n_q <= nbits_q;
                            if (chain) begin
                                fs_q       <= 1'b1;
                                sh_q       <= tx_data;
                                nbits_q    <= width_req;
                                bit_left_q <= width_req;
                            end
                        end else begin
                            state_q    <= ENG_GAP;
                            oe_q       <= 1'b0;
                            txd_q      <= 1'b0;
                            fs_q       <= 1'b0;
                            dphase_q   <= 1'b0;
                            gap_half_q <= 1'b0;
                        end
                    end
                end
                ENG_GAP: begin
                    if (!half_tick) begin
                        div_cnt_q <= div_cnt_q + 1'b1;
                    end else begin
                        div_cnt_q  <= '0;
                        gap_half_q <= 1'b1;
                        if (gap_half_q) state_q <= ENG_IDLE;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign sclk   = sclk_q;
    assign fsync  = fs_q;
    assign txd    = txd_q;
    assign txd_oe = oe_q;

    AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ENG_RUN) |-> (!sclk_q && !fs_q && !oe_q)); // R1
    AST_FS_RISES_WITH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_q) |-> $rose(sclk_q)); // R2
    AST_FS_ENDS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fs_q) |-> ($rose(sclk_q) && oe_q)); // R4
    AST_RX_DURING_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (oe_q && sclk_q)); // R6
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (!tx_empty && en)); // R3
endmodule

// File: rtl/fps_master.sv
`timescale 1ns/1ps
// Frame-pulse synchronous serial master (top).
// Does: joins the transmit and receive queues, the frame sequencer and the
// DMA request logic, and keeps the sticky receive-overrun flag.
// Assumes: a single clock domain; rxd is already synchronous to clk.
module fps_master #(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned DIV_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_enable,
    input  logic                         cfg_continuous,
    input  logic [$clog2(DATA_W+1)-1:0]  cfg_frame_bits,
    input  logic [DIV_W-1:0]             cfg_half_div,
    input  logic                         cfg_tx_dma_en,
    input  logic                         cfg_rx_dma_en,
    input  logic                         tx_wr_en,
    input  logic [DATA_W-1:0]            tx_wr_data,
    output logic                         tx_full,
    input  logic                         rx_rd_en,
    output logic [DATA_W-1:0]            rx_rd_data,
    output logic                         rx_empty,
    output logic                         rx_overrun,
    input  logic                         rx_ovr_clr,
    output logic                         tx_dma_req,
    output logic                         rx_dma_req,
    output logic                         sclk,
    output logic                         fsync,
    output logic                         txd,
    output logic                         txd_oe,
    input  logic                         rxd
);
    localparam int unsigned CW = $clog2(FIFO_DEPTH+1);

    logic              tx_empty, tx_pop, rx_push, rx_full, ovr_q;
    logic [DATA_W-1:0] tx_head, rx_word;
    logic [CW-1:0]     tx_level, rx_level;

    fps_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr_en), .wdata(tx_wr_data), .pop(tx_pop),
        .rdata(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    fps_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_word), .pop(rx_rd_en),
        .rdata(rx_rd_data), .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    fps_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .en(cfg_enable), .continuous(cfg_continuous),
        .cfg_bits(cfg_frame_bits), .cfg_div(cfg_half_div),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_word), .rxd(rxd),
        .sclk(sclk), .fsync(fsync), .txd(txd), .txd_oe(txd_oe)
    );

    fps_dma_req #(.DEPTH(FIFO_DEPTH)) u_dma (
        .clk(clk), .rst_n(rst_n),
        .tx_en(cfg_tx_dma_en), .rx_en(cfg_rx_dma_en),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_req(tx_dma_req), .rx_req(rx_dma_req)
    );

    // Sticky overrun: set on a dropped receive frame, cleared on request
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovr_q <= 1'b0;
        else if (rx_push && rx_full) ovr_q <= 1'b1;
        else if (rx_ovr_clr)         ovr_q <= 1'b0;
    end

    assign rx_overrun = ovr_q;

    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> rx_overrun); // R12
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_ovr_clr) |=> rx_overrun); // R12
    AST_TX_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx_dma_en |-> !tx_dma_req); // R10
endmodule

// File: tb/fps_master_bench.sv
`timescale 1ns/1ps
module fps_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_continuous = 1'b0;
    logic [4:0]  cfg_frame_bits = 5'd8;
    logic [7:0]  cfg_half_div = 8'd2;
    logic        cfg_tx_dma_en = 1'b0, cfg_rx_dma_en = 1'b0;
    logic        tx_wr_en = 1'b0;
    logic [15:0] tx_wr_data = '0;
    logic        tx_full, rx_empty, rx_overrun, tx_dma_req, rx_dma_req;
    logic        rx_rd_en = 1'b0, rx_ovr_clr = 1'b0;
    logic [15:0] rx_rd_data;
    logic        sclk, fsync, txd, txd_oe, rxd;
    logic        rx_inv = 1'b0;

    int pass_n = 0, fail_n = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign rxd = txd ^ rx_inv;

    fps_master u_fps_master (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_continuous(cfg_continuous),
        .cfg_frame_bits(cfg_frame_bits), .cfg_half_div(cfg_half_div),
        .cfg_tx_dma_en(cfg_tx_dma_en), .cfg_rx_dma_en(cfg_rx_dma_en),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .rx_overrun(rx_overrun), .rx_ovr_clr(rx_ovr_clr),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .sclk(sclk), .fsync(fsync), .txd(txd), .txd_oe(txd_oe), .rxd(rxd)
    );

    // Pin-level frame capture on falling serial clock
    int          mon_bits = 8;
    bit          mon_active = 1'b0;
    int          mon_cnt = 0;
    logic [15:0] mon_sh = '0;
    logic [15:0] cap_w [64];
    int          cap_n = 0;

    always @(negedge sclk) begin
        if (txd_oe && mon_active) begin
            mon_sh = {mon_sh[14:0], txd};
            mon_cnt++;
            if (mon_cnt == mon_bits) begin
                if (cap_n < 64) cap_w[cap_n] = mon_sh;
                cap_n++;
                mon_active = 1'b0;
            end
        end
        if (fsync) begin
            mon_active = 1'b1;
            mon_cnt = 0;
            mon_sh = '0;
        end
    end

    // Sync pulse timing and output-enable activity, sampled mid-cycle
    int cyc = 0, rise_n = 0, fs_run = 0, oe_falls = 0;
    int rise_t [64];
    int fs_w [64];
    bit fs_prev = 1'b0, oe_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (fsync && !fs_prev) begin
            if (rise_n < 64) rise_t[rise_n] = cyc;
            fs_run = 0;
        end
        if (fsync) fs_run++;
        if (!fsync && fs_prev) begin
            if (rise_n < 64) fs_w[rise_n] = fs_run;
            rise_n++;
        end
        if (!txd_oe && oe_prev) oe_falls++;
        fs_prev = fsync;
        oe_prev = txd_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        if (ok) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        cfg_enable = 1'b0; cfg_continuous = 1'b0;
        cfg_frame_bits = 5'd8; cfg_half_div = 8'd2;
        cfg_tx_dma_en = 1'b0; cfg_rx_dma_en = 1'b0;
        tx_wr_en = 1'b0; rx_rd_en = 1'b0; rx_ovr_clr = 1'b0; rx_inv = 1'b0;
        mon_bits = 8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [15:0] w);
        tx_wr_data = w;
        tx_wr_en = 1'b1;
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    task automatic pop_rx(output logic [15:0] w);
        w = rx_rd_data;
        rx_rd_en = 1'b1;
        @(negedge clk);
        rx_rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        apply_reset();
        chk(!sclk && !fsync && !txd_oe, "R1 idle pins after reset", {sclk, fsync, txd_oe}, 0);
        chk(!tx_full && rx_empty, "R1 queue flags after reset", {tx_full, rx_empty}, 1);
        chk(!tx_dma_req && !rx_dma_req, "R1 dma requests after reset", {tx_dma_req, rx_dma_req}, 0);
        chk(!rx_overrun, "R12 overrun clear after reset", rx_overrun, 0);
    endtask

    task automatic test_single();
        int cb, rb, ob;
        logic [15:0] w;
        apply_reset();
        cb = cap_n; rb = rise_n; ob = oe_falls;
        cfg_enable = 1'b1;
        push(16'h00A5);
        push(16'h003C);
        wait_cyc(150);
        chk(cap_n - cb == 2, "R3 frames sent from queue", cap_n - cb, 2);
        chk(cap_w[cb] == 16'hA5, "R4 first frame MSB first", cap_w[cb], 16'hA5);
        chk(cap_w[cb+1] == 16'h3C, "R4 second frame", cap_w[cb+1], 16'h3C);
        chk(fs_w[rb] == 4, "R2 sync width one period", fs_w[rb], 4);
        chk(rise_t[rb+1] - rise_t[rb] >= 40, "R8 single-mode spacing", rise_t[rb+1] - rise_t[rb], 40);
        chk(oe_falls - ob == 2, "R8 oe drops after each frame", oe_falls - ob, 2);
        chk(!sclk && !fsync && !txd_oe, "R1 idle pins after frames", {sclk, fsync, txd_oe}, 0);
        pop_rx(w);
        chk(w == 16'h00A5, "R6 loopback word 0", w, 16'h00A5);
        pop_rx(w);
        chk(w == 16'h003C, "R6 loopback word 1", w, 16'h003C);
    endtask

    task automatic test_widths();
        int cb, rb;
        logic [15:0] w;
        apply_reset();
        cfg_enable = 1'b1;
        cfg_frame_bits = 5'd2;
        mon_bits = 4;
        cb = cap_n;
        push(16'hFFF9);
        wait_cyc(100);
        chk(cap_w[cb] == 16'h0009, "R5 width below 4 clamps to 4", cap_w[cb], 16'h0009);
        pop_rx(w);
        chk(w == 16'h0009, "R6 narrow word zero-extended", w, 16'h0009);
        cfg_frame_bits = 5'd16;
        cfg_half_div = 8'd3;
        mon_bits = 16;
        rx_inv = 1'b1;
        cb = cap_n; rb = rise_n;
        push(16'h1234);
        wait_cyc(250);
        chk(cap_w[cb] == 16'h1234, "R5 full 16-bit frame", cap_w[cb], 16'h1234);
        chk(fs_w[rb] == 6, "R13 period follows half divider", fs_w[rb], 6);
        pop_rx(w);
        chk(w == 16'hEDCB, "R6 inverted reply captured", w, 16'hEDCB);
    endtask

    task automatic test_cont();
        int cb, rb, ob;
        apply_reset();
        cfg_continuous = 1'b1;
        rb = rise_n;
        push(16'h0081);
        push(16'h0042);
        push(16'h00C3);
        wait_cyc(20);
        chk(rise_n == rb, "R3 no frame while disabled", rise_n - rb, 0);
        cb = cap_n; ob = oe_falls;
        cfg_enable = 1'b1;
        wait_cyc(200);
        chk(cap_n - cb == 3, "R7 burst frame count", cap_n - cb, 3);
        chk(cap_w[cb] == 16'h81 && cap_w[cb+1] == 16'h42 && cap_w[cb+2] == 16'hC3,
            "R4 burst words in order", cap_w[cb+1], 16'h42);
        chk(rise_t[rb+1] - rise_t[rb] == 32, "R7 spacing frame 0 to 1", rise_t[rb+1] - rise_t[rb], 32);
        chk(rise_t[rb+2] - rise_t[rb+1] == 32, "R7 spacing frame 1 to 2", rise_t[rb+2] - rise_t[rb+1], 32);
        chk(oe_falls - ob == 1, "R7 oe held across burst", oe_falls - ob, 1);
        chk(fs_w[rb+1] == 4, "R2 overlapped sync width", fs_w[rb+1], 4);
    endtask

    task automatic test_full();
        int cb;
        logic [15:0] w;
        apply_reset();
        for (int i = 0; i < 9; i++) push(16'h0010 + 16'(i));
        chk(tx_full, "R9 queue full after 8 writes", tx_full, 1);
        cb = cap_n;
        cfg_continuous = 1'b1;
        cfg_enable = 1'b1;
        wait_cyc(400);
        chk(cap_n - cb == 8, "R9 ninth write dropped", cap_n - cb, 8);
        chk(cap_w[cb+7] == 16'h0017, "R9 last frame is eighth word", cap_w[cb+7], 16'h0017);
        chk(!rx_overrun, "R12 no overrun at exactly full", rx_overrun, 0);
        for (int i = 0; i < 8; i++) begin
            pop_rx(w);
            chk(w == 16'h0010 + 16'(i), "R6 received order", w, 16'h0010 + i);
        end
    endtask

    task automatic test_dma();
        logic [15:0] w;
        apply_reset();
        chk(!tx_dma_req, "R10 tx request off when disabled", tx_dma_req, 0);
        cfg_tx_dma_en = 1'b1;
        @(negedge clk);
        chk(tx_dma_req, "R10 tx request when empty", tx_dma_req, 1);
        for (int i = 0; i < 4; i++) push(16'h0050 + 16'(i));
        chk(tx_dma_req, "R10 tx request at half full", tx_dma_req, 1);
        push(16'h0054);
        chk(!tx_dma_req, "R10 tx request off above half", tx_dma_req, 0);
        cfg_rx_dma_en = 1'b1;
        @(negedge clk);
        chk(!rx_dma_req, "R11 rx request off when empty", rx_dma_req, 0);
        cfg_continuous = 1'b1;
        cfg_enable = 1'b1;
        wait_cyc(300);
        chk(rx_dma_req, "R11 rx request at 5 entries", rx_dma_req, 1);
        chk(tx_dma_req, "R10 tx request after draining", tx_dma_req, 1);
        cfg_rx_dma_en = 1'b0;
        @(negedge clk);
        chk(!rx_dma_req, "R11 rx request gated by enable", rx_dma_req, 0);
        cfg_rx_dma_en = 1'b1;
        pop_rx(w);
        chk(rx_dma_req, "R11 rx request at exactly 4", rx_dma_req, 1);
        pop_rx(w);
        chk(!rx_dma_req, "R11 rx request off at 3", rx_dma_req, 0);
    endtask

    task automatic test_overrun();
        logic [15:0] w;
        apply_reset();
        cfg_continuous = 1'b1;
        for (int i = 0; i < 8; i++) push(16'h0040 + 16'(i));
        cfg_enable = 1'b1;
        wait_cyc(20);
        push(16'h0048);
        wait_cyc(500);
        chk(rx_overrun, "R12 overrun on ninth frame", rx_overrun, 1);
        wait_cyc(10);
        chk(rx_overrun, "R12 overrun sticky", rx_overrun, 1);
        pop_rx(w);
        chk(w == 16'h0040, "R12 oldest word kept", w, 16'h0040);
        for (int i = 1; i < 8; i++) pop_rx(w);
        chk(w == 16'h0047, "R12 eighth word last", w, 16'h0047);
        chk(rx_empty, "R12 ninth frame dropped", rx_empty, 1);
        chk(rx_overrun, "R12 flag survives reads", rx_overrun, 1);
        rx_ovr_clr = 1'b1;
        @(negedge clk);
        rx_ovr_clr = 1'b0;
        chk(!rx_overrun, "R12 flag cleared", rx_overrun, 0);
    endtask

    initial begin
        test_reset();
        test_single();
        test_widths();
        test_cont();
        test_full();
        test_dma();
        test_overrun();
        done = 1'b1;
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fail_n++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
            $finish;
        end
    end
endmodule